// File: doc/BRIEF.md
# Reconfiguration session handshake engine

This block ends a light reliable transport that runs over UDP and feeds a partial reconfiguration controller. Upstream logic has already stripped the Ethernet, IP and UDP layers. It hands over the 8-byte transport header as the first 64-bit beat of a packet, then the payload beats, and holds the sender's IPv4 address beside them. The engine decodes the request kind and keeps a small table of live sessions. Each live session binds a session number to one sender address. The engine accepts or silently drops each request.

Accepted download packets go into an external dual-port word buffer. Each packet lands at a word offset computed from its sequence number, so packets that arrive out of order or are repeated still leave the bitstream in order. The engine keeps the announced bitstream size for each session. On a start request it passes that size and a one-cycle start strobe to the configuration-port controller, and it waits for that controller to report completion. Every accepted request produces one acknowledgement descriptor for the transmit path. That descriptor carries the reply kind, the session number, a 32-bit value and the address of the host to answer.

Top module: `recfg_session_engine`

## Requirements
- R1: While reset is high, and after it, until a request is accepted, `ack_valid`, `buf_we` and `cfg_start` are 0 and `cfg_size` is 0.
- R2: A header beat has `rx_sop` high and puts byte k on `rx_data[8k+7:8k]`. The fields are: byte 0, request kind; byte 1, session number; bytes 2..5, a 32-bit value with byte 2 most significant; bytes 6..7, payload length with byte 6 most significant. The kind codes are 0x01 open, 0x02 size announce, 0x03 data, 0x04 start, 0x05 close. The reply kind is the request kind OR 0x80.
- R3: An open request takes the lowest free session number in 1..NUM_SESS (default 2), binds it to `rx_src_ip` and replies with that number and a value of 0. When no slot is free, it gets no reply and changes nothing.
- R4: Every other request kind is accepted only when its session number is live and bound to `rx_src_ip`. A request that fails this match, or has an unknown kind, gives no reply, no buffer write and no state change.
- R5: A size announce stores the 32-bit value as that session's bitstream size and replies with the same value.
- R6: The payload of a data packet with sequence number s is written to word address s*183 + b, where b is the payload beat index from 0. Byte enables cover only the first `len` bytes: 0xFF for full words, and the low (len mod 8) bits on the last partial word. Beats past `len` are not written. Each write appears on the cycle after its beat.
- R7: A data packet whose length exceeds 1464, or whose sequence number is 358 or more (floor(65536/183)), is dropped.
- R8: An accepted start request pulses `cfg_start` for one cycle, on the cycle after the header, with `cfg_size` equal to the session's stored size. Its reply, with a value of 0, comes on the cycle after `cfg_done` is sampled high. Every request that arrives in between is dropped.
- R9: A close request frees the session number and replies with a value of 0. After that, requests under that number are dropped until an open request allocates it again.
- R10: A repeated data packet with the same sequence number is written again to the same addresses and acknowledged again.
- R11: The reply to a request other than start is given on the cycle after its last beat (`rx_eop`). Its value is the sequence number for data packets, and `ack_ip` is the requester's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receive beat valid |
| rx_sop | input | 1 | Beat is the transport header |
| rx_eop | input | 1 | Last beat of the packet |
| rx_data | input | 64 | Header or payload beat |
| rx_src_ip | input | 32 | Sender IPv4 address, held for the packet |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | clog2(BUF_WORDS) | Buffer word address |
| buf_wdata | output | 64 | Buffer write data |
| buf_be | output | 8 | Buffer byte enables |
| cfg_start | output | 1 | One-cycle start strobe to the configuration controller |
| cfg_size | output | 32 | Bitstream size for the configuration controller |
| cfg_done | input | 1 | Configuration controller finished |
| ack_valid | output | 1 | Acknowledgement descriptor valid (one cycle) |
| ack_type | output | 8 | Reply kind |
| ack_sid | output | 8 | Session number |
| ack_field | output | 32 | Reply value |
| ack_ip | output | 32 | Host address to reply to |

## Verification
A wrong session binding shows up at the very next request from the affected host. It appears on the cycle after that packet's last beat, as either a missing reply or an unexpected one. A wrong write pointer or byte-count register is visible one cycle after the first affected payload beat, as a wrong address or wrong enables on the buffer port. A stuck wait state for the configuration controller shows up as a missing start reply after `cfg_done`, or as silence to the next request. Because the outputs are compared with a reference model every cycle, each of these faults is caught within a cycle of its first visible effect.

// File: rtl/recfg_pkg.sv
package recfg_pkg;

  // request kinds carried in header byte 0
  localparam logic [7:0] HS_OPEN  = 8'h01;
  localparam logic [7:0] HS_SIZE  = 8'h02;
  localparam logic [7:0] HS_DATA  = 8'h03;
  localparam logic [7:0] HS_START = 8'h04;
  localparam logic [7:0] HS_CLOSE = 8'h05;
  localparam logic [7:0] REPLY_BIT = 8'h80;

  typedef struct packed {
    logic [7:0]  kind;
    logic [7:0]  sid;
    logic [31:0] value;
    logic [15:0] len;
  } xport_hdr_t;

  // byte k of the header sits at bits [8k+7:8k]; multi-byte fields are big-endian
  function automatic xport_hdr_t decode_hdr(input logic [63:0] w);
    xport_hdr_t h;
    h.kind  = w[7:0];
    h.sid   = w[15:8];
    h.value = {w[23:16], w[31:24], w[39:32], w[47:40]};
    h.len   = {w[55:48], w[63:56]};
    return h;
  endfunction

endpackage

// File: rtl/recfg_sess_table.sv
module recfg_sess_table #(
  parameter int NUM_SESS = 2,
  parameter int SZW      = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [7:0]     q_sid,
  input  logic [31:0]    q_ip,
  output logic           q_hit,
  output logic [SZW-1:0] q_size,
  output logic           free_ok,
  output logic [7:0]     free_sid,
  input  logic           alloc_en,
  input  logic           rel_en,
  input  logic           info_en,
  input  logic [SZW-1:0] info_size
);

  logic           live   [NUM_SESS];
  logic [31:0]    owner  [NUM_SESS];
  logic [SZW-1:0] bsize  [NUM_SESS];

  for (genvar g = 0; g < NUM_SESS; g++) begin : g_slot
    logic           v_q;
    logic [31:0]    ip_q;
    logic [SZW-1:0] sz_q;
    logic           is_me;

    assign is_me = (q_sid == 8'(g + 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q  <= 1'b0;
        ip_q <= '0;
        sz_q <= '0;
      end else begin
        if (alloc_en && free_sid == 8'(g + 1)) begin
          v_q  <= 1'b1;
          ip_q <= q_ip;
        end else if (rel_en && is_me) begin
          v_q <= 1'b0;
        end
        if (info_en && is_me) sz_q <= info_size;
      end
    end

    assign live[g]  = v_q;
    assign owner[g] = ip_q;
    assign bsize[g] = sz_q;
  end

  always_comb begin
    q_hit  = 1'b0;
    q_size = '0;
    for (int s = 0; s < NUM_SESS; s++) begin
      if (q_sid == 8'(s + 1)) begin
        q_size = bsize[s];
        if (live[s] && owner[s] == q_ip) q_hit = 1'b1;
      end
    end
  end

  always_comb begin
    free_ok  = 1'b0;
    free_sid = '0;
    for (int s = NUM_SESS - 1; s >= 0; s--) begin
      if (!live[s]) begin
        free_ok  = 1'b1;
        free_sid = 8'(s + 1);
      end
    end
  end

  // R3
  alloc_has_slot_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_en |-> free_ok);

  // R9
  release_frees_chk: assert property (@(posedge clk) disable iff (rst)
    rel_en |=> free_ok);

  // R4
  release_owned_chk: assert property (@(posedge clk) disable iff (rst)
    rel_en |-> q_hit);

endmodule

// File: rtl/recfg_payload_wr.sv
module recfg_payload_wr #(
  parameter int AW   = 16,
  parameter int LENW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [AW-1:0]   load_base,
  input  logic [LENW-1:0] load_len,
  input  logic            beat,
  input  logic [63:0]     beat_data,
  output logic            buf_we,
  output logic [AW-1:0]   buf_addr,
  output logic [63:0]     buf_wdata,
  output logic [7:0]      buf_be
);

  logic [AW-1:0]   wptr;
  logic [LENW-1:0] left;
  logic [7:0]      mask;

  always_comb begin
    if (left >= LENW'(8)) mask = 8'hFF;
    else                  mask = (8'h01 << left[2:0]) - 8'h01;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      left      <= '0;
      buf_we    <= 1'b0;
      buf_addr  <= '0;
      buf_wdata <= '0;
      buf_be    <= '0;
    end else begin
      buf_we <= 1'b0;
      if (load) begin
        wptr <= load_base;
        left <= load_len;
      end else if (beat && left != '0) begin
        buf_we    <= 1'b1;
        buf_addr  <= wptr;
        buf_wdata <= beat_data;
        buf_be    <= mask;
        wptr      <= wptr + 1'b1;
        left      <= (left > LENW'(8)) ? left - LENW'(8) : '0;
      end
    end
  end

  // R6
  write_needs_beat_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(beat));

  // R6
  write_has_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> buf_be != 8'h00);

endmodule

// File: rtl/recfg_session_engine.sv
module recfg_session_engine
  import recfg_pkg::*;
#(
  parameter int NUM_SESS    = 2,
  parameter int MAX_PAYLOAD = 1464,
  parameter int BUF_WORDS   = 65536,
  localparam int AW         = $clog2(BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rx_sop,
  input  logic          rx_eop,
  input  logic [63:0]   rx_data,
  input  logic [31:0]   rx_src_ip,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [63:0]   buf_wdata,
  output logic [7:0]    buf_be,
  output logic          cfg_start,
  output logic [31:0]   cfg_size,
  input  logic          cfg_done,
  output logic          ack_valid,
  output logic [7:0]    ack_type,
  output logic [7:0]    ack_sid,
  output logic [31:0]   ack_field,
  output logic [31:0]   ack_ip
);

  localparam int WPP      = MAX_PAYLOAD / 8;
  localparam int MAX_PKTS = BUF_WORDS / WPP;

  xport_hdr_t  h;
  logic        hdr_beat, waiting, in_pkt;
  logic        q_hit, free_ok, accept, take, data_ok;
  logic [7:0]  free_sid, rsid_n;
  logic [31:0] q_size, rval_n;
  logic [7:0]  pend_type, pend_sid, start_sid;
  logic [31:0] pend_val, pend_ip, start_ip;
  logic [AW-1:0] wr_base;
  logic [15:0]   wr_len;

  assign h        = decode_hdr(rx_data);
  assign hdr_beat = rx_valid && rx_sop;
  assign data_ok  = q_hit && (h.len <= 16'(MAX_PAYLOAD)) && (h.value < 32'(MAX_PKTS));

  always_comb begin
    accept = 1'b0;
    rsid_n = h.sid;
    rval_n = '0;
    case (h.kind)
      HS_OPEN:  begin accept = free_ok; rsid_n = free_sid; end
      HS_SIZE:  begin accept = q_hit;   rval_n = h.value;  end
      HS_DATA:  begin accept = data_ok; rval_n = h.value;  end
      HS_START: accept = q_hit;
      HS_CLOSE: accept = q_hit;
      default:  accept = 1'b0;
    endcase
    if (waiting) accept = 1'b0;
  end

  assign take = hdr_beat && accept;

  recfg_sess_table #(.NUM_SESS(NUM_SESS), .SZW(32)) u_table (
    .clk       (clk),
    .rst       (rst),
    .q_sid     (h.sid),
    .q_ip      (rx_src_ip),
    .q_hit     (q_hit),
    .q_size    (q_size),
    .free_ok   (free_ok),
    .free_sid  (free_sid),
    .alloc_en  (take && h.kind == HS_OPEN),
    .rel_en    (take && h.kind == HS_CLOSE),
    .info_en   (take && h.kind == HS_SIZE),
    .info_size (h.value)
  );

  assign wr_base = h.value[AW-1:0] * AW'(WPP);
  assign wr_len  = (take && h.kind == HS_DATA) ? h.len : 16'd0;

  recfg_payload_wr #(.AW(AW), .LENW(16)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .load      (hdr_beat),
    .load_base (wr_base),
    .load_len  (wr_len),
    .beat      (rx_valid && !rx_sop && in_pkt),
    .beat_data (rx_data),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_wdata (buf_wdata),
    .buf_be    (buf_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting   <= 1'b0;
      in_pkt    <= 1'b0;
      pend_type <= '0;
      pend_sid  <= '0;
      pend_val  <= '0;
      pend_ip   <= '0;
      start_sid <= '0;
      start_ip  <= '0;
      cfg_start <= 1'b0;
      cfg_size  <= '0;
      ack_valid <= 1'b0;
      ack_type  <= '0;
      ack_sid   <= '0;
      ack_field <= '0;
      ack_ip    <= '0;
    end else begin
      ack_valid <= 1'b0;
      cfg_start <= 1'b0;
      if (hdr_beat) begin
        in_pkt    <= take && !rx_eop && h.kind != HS_START;
        pend_type <= h.kind | REPLY_BIT;
        pend_sid  <= rsid_n;
        pend_val  <= rval_n;
        pend_ip   <= rx_src_ip;
        if (take && rx_eop && h.kind != HS_START) begin
          ack_valid <= 1'b1;
          ack_type  <= h.kind | REPLY_BIT;
          ack_sid   <= rsid_n;
          ack_field <= rval_n;
          ack_ip    <= rx_src_ip;
        end
        if (take && h.kind == HS_START) begin
          cfg_start <= 1'b1;
          cfg_size  <= q_size;
          waiting   <= 1'b1;
          start_sid <= h.sid;
          start_ip  <= rx_src_ip;
        end
      end else if (rx_valid && rx_eop && in_pkt) begin
        in_pkt    <= 1'b0;
        ack_valid <= 1'b1;
        ack_type  <= pend_type;
        ack_sid   <= pend_sid;
        ack_field <= pend_val;
        ack_ip    <= pend_ip;
      end
      if (waiting && cfg_done) begin
        waiting   <= 1'b0;
        ack_valid <= 1'b1;
        ack_type  <= HS_START | REPLY_BIT;
        ack_sid   <= start_sid;
        ack_field <= '0;
        ack_ip    <= start_ip;
      end
    end
  end

  // R11
  ack_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(rx_valid && rx_eop) || $past(cfg_done));

  // R8
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_start |=> !cfg_start);

  // R8
  start_ack_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_type == (HS_START | REPLY_BIT)) |-> $past(cfg_done));

  // R3
  open_ack_sid_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_type == (HS_OPEN | REPLY_BIT)) |-> (ack_sid != 8'd0 && ack_sid <= 8'(NUM_SESS)));

  // R6
  write_after_payload_chk: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(rx_valid && !rx_sop));

endmodule

// File: tb/test_recfg_session_engine.sv
`timescale 1ns/1ps
module test_recfg_session_engine;

  localparam logic [7:0] K_OPEN = 8'h01, K_SIZE = 8'h02, K_DATA = 8'h03,
                         K_START = 8'h04, K_CLOSE = 8'h05;
  localparam logic [31:0] IP_A = 32'h0A00_0001, IP_B = 32'h0A00_0002, IP_C = 32'h0A00_0003;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic [63:0] rx_data = '0;
  logic [31:0] rx_src_ip = '0;
  logic        cfg_done = 1'b0;
  logic        buf_we, cfg_start, ack_valid;
  logic [15:0] buf_addr;
  logic [63:0] buf_wdata;
  logic [7:0]  buf_be, ack_type, ack_sid;
  logic [31:0] cfg_size, ack_field, ack_ip;

  recfg_session_engine i_recfg_session_engine (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_data(rx_data), .rx_src_ip(rx_src_ip), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_be(buf_be), .cfg_start(cfg_start), .cfg_size(cfg_size),
    .cfg_done(cfg_done), .ack_valid(ack_valid), .ack_type(ack_type), .ack_sid(ack_sid),
    .ack_field(ack_field), .ack_ip(ack_ip)
  );

  int    cyc = 0;
  int    n_chk = 0, n_bad = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { logic [7:0] t; logic [7:0] s; logic [31:0] v; logic [31:0] ip; string tag; } ack_e;
  typedef struct { logic [15:0] a; logic [63:0] d; logic [7:0] be; string tag; } wr_e;
  typedef struct { logic [31:0] sz; string tag; } st_e;
  ack_e exp_ack[int];
  wr_e  exp_wr[int];
  st_e  exp_st[int];

  // reference session state
  bit          r_live[1:2];
  logic [31:0] r_ip[1:2];
  logic [31:0] r_sz[1:2];
  bit          r_wait = 1'b0;
  logic [7:0]  r_ssid;
  logic [31:0] r_sip;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (exp_ack.exists(cyc)) begin
        chk(ack_valid === 1'b1, exp_ack[cyc].tag, "ack_valid", 64'(ack_valid), 64'd1);
        chk(ack_type === exp_ack[cyc].t, exp_ack[cyc].tag, "ack_type", 64'(ack_type), 64'(exp_ack[cyc].t));
        chk(ack_sid === exp_ack[cyc].s, exp_ack[cyc].tag, "ack_sid", 64'(ack_sid), 64'(exp_ack[cyc].s));
        chk(ack_field === exp_ack[cyc].v, exp_ack[cyc].tag, "ack_field", 64'(ack_field), 64'(exp_ack[cyc].v));
        chk(ack_ip === exp_ack[cyc].ip, exp_ack[cyc].tag, "ack_ip", 64'(ack_ip), 64'(exp_ack[cyc].ip));
        exp_ack.delete(cyc);
      end else begin
        chk(ack_valid === 1'b0, cur_tag, "unexpected ack_valid", 64'(ack_valid), 64'd0);
      end
      if (exp_wr.exists(cyc)) begin
        chk(buf_we === 1'b1, exp_wr[cyc].tag, "buf_we", 64'(buf_we), 64'd1);
        chk(buf_addr === exp_wr[cyc].a, exp_wr[cyc].tag, "buf_addr", 64'(buf_addr), 64'(exp_wr[cyc].a));
        chk(buf_wdata === exp_wr[cyc].d, exp_wr[cyc].tag, "buf_wdata", buf_wdata, exp_wr[cyc].d);
        chk(buf_be === exp_wr[cyc].be, exp_wr[cyc].tag, "buf_be", 64'(buf_be), 64'(exp_wr[cyc].be));
        exp_wr.delete(cyc);
      end else begin
        chk(buf_we === 1'b0, cur_tag, "unexpected buf_we", 64'(buf_we), 64'd0);
      end
      if (exp_st.exists(cyc)) begin
        chk(cfg_start === 1'b1, exp_st[cyc].tag, "cfg_start", 64'(cfg_start), 64'd1);
        chk(cfg_size === exp_st[cyc].sz, exp_st[cyc].tag, "cfg_size", 64'(cfg_size), 64'(exp_st[cyc].sz));
        exp_st.delete(cyc);
      end else begin
        chk(cfg_start === 1'b0, cur_tag, "unexpected cfg_start", 64'(cfg_start), 64'd0);
      end
    end
  end

  // R2: byte 0 kind, byte 1 session, bytes 2..5 value (MSB first), bytes 6..7 length (MSB first)
  function automatic logic [63:0] mk_hdr(input logic [7:0] t, input logic [7:0] s,
                                         input logic [31:0] v, input logic [15:0] l);
    return {l[7:0], l[15:8], v[7:0], v[15:8], v[23:16], v[31:24], s, t};
  endfunction

  function automatic logic [63:0] pay_word(input logic [31:0] seq, input int k);
    return {seq[15:0], 16'(k), 32'hA5C3_0000 ^ 32'(k)};
  endfunction

  task automatic drive(input bit sop, input bit eop, input logic [63:0] d,
                       input logic [31:0] ip, output int c);
    @(negedge clk);
    c = cyc;
    rx_valid  = 1'b1;
    rx_sop    = sop;
    rx_eop    = eop;
    rx_data   = d;
    rx_src_ip = ip;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b0;
      rx_sop   = 1'b0;
      rx_eop   = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] t, input logic [7:0] s, input logic [31:0] v,
                      input logic [15:0] l, input logic [31:0] ip, input int npay,
                      input string tag);
    bit         acc;
    logic [7:0] rs;
    logic [31:0] rv;
    bit         hit;
    int         c;
    cur_tag = tag;
    acc = 1'b0;
    rs  = s;
    rv  = 32'd0;
    hit = (s == 8'd1 || s == 8'd2) && r_live[int'(s)] && r_ip[int'(s)] == ip;
    case (t)
      K_OPEN: begin
        for (int i = 2; i >= 1; i--) if (!r_live[i]) begin acc = 1'b1; rs = 8'(i); end
      end
      K_SIZE:  begin acc = hit; rv = v; end
      K_DATA:  begin acc = hit && l <= 16'd1464 && v < 32'd358; rv = v; end
      K_START: acc = hit;
      K_CLOSE: acc = hit;
      default: acc = 1'b0;
    endcase
    if (r_wait) acc = 1'b0;
    drive(1'b1, npay == 0, mk_hdr(t, s, v, l), ip, c);
    if (acc) begin
      if (t == K_OPEN)  begin r_live[int'(rs)] = 1'b1; r_ip[int'(rs)] = ip; end
      if (t == K_SIZE)  r_sz[int'(s)] = v;
      if (t == K_CLOSE) r_live[int'(s)] = 1'b0;
      if (t == K_START) begin
        exp_st[c + 1] = '{sz: r_sz[int'(s)], tag: tag};
        r_wait = 1'b1;
        r_ssid = s;
        r_sip  = ip;
      end else begin
        exp_ack[c + npay + 1] = '{t: t | 8'h80, s: rs, v: rv, ip: ip, tag: tag};
      end
    end
    for (int k = 1; k <= npay; k++) begin
      int c2;
      int rem;
      drive(1'b0, k == npay, pay_word(v, k - 1), ip, c2);
      rem = int'(l) - 8 * (k - 1);
      if (acc && t == K_DATA && rem > 0)
        exp_wr[c2 + 1] = '{a: 16'(v * 183 + 32'(k - 1)), d: pay_word(v, k - 1),
                          be: (rem >= 8) ? 8'hFF : 8'((1 << rem) - 1), tag: tag};
    end
    idle(1);
  endtask

  task automatic finish_start(input string tag);
    int c;
    cur_tag = tag;
    @(negedge clk);
    c = cyc;
    cfg_done = 1'b1;
    if (r_wait) exp_ack[c + 1] = '{t: K_START | 8'h80, s: r_ssid, v: 32'd0, ip: r_sip, tag: tag};
    r_wait = 1'b0;
    @(negedge clk);
    cfg_done = 1'b0;
  endtask

  initial begin
    r_live[1] = 1'b0; r_live[2] = 1'b0;
    r_ip[1] = '0; r_ip[2] = '0; r_sz[1] = '0; r_sz[2] = '0;
    r_ssid = '0; r_sip = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ack_valid === 1'b0, "R1", "ack_valid in reset", 64'(ack_valid), 64'd0);
    chk(buf_we === 1'b0, "R1", "buf_we in reset", 64'(buf_we), 64'd0);
    chk(cfg_start === 1'b0, "R1", "cfg_start in reset", 64'(cfg_start), 64'd0);
    chk(cfg_size === 32'd0, "R1", "cfg_size in reset", 64'(cfg_size), 64'd0);
    rst = 1'b0;
    idle(3);

    send(K_OPEN, 8'd0, 32'd0, 16'd0, IP_A, 0, "R3 R2 R11 open A");
    send(K_OPEN, 8'd0, 32'd0, 16'd0, IP_B, 0, "R3 open B");
    send(K_OPEN, 8'd0, 32'd0, 16'd0, IP_C, 0, "R3 open when full");
    send(K_SIZE, 8'd1, 32'd3000, 16'd0, IP_A, 0, "R5 size announce");
    send(K_SIZE, 8'd1, 32'd77, 16'd0, IP_B, 0, "R4 wrong address");
    send(K_SIZE, 8'd7, 32'd77, 16'd0, IP_A, 0, "R4 unknown session");
    send(8'h09, 8'd1, 32'd0, 16'd0, IP_A, 0, "R4 unknown kind");
    send(K_DATA, 8'd1, 32'd0, 16'd1464, IP_A, 183, "R6 full packet");
    send(K_DATA, 8'd1, 32'd2, 16'd13, IP_A, 3, "R6 short last packet");
    send(K_DATA, 8'd1, 32'd1, 16'd20, IP_A, 3, "R11 data ack");
    send(K_DATA, 8'd1, 32'd1, 16'd20, IP_A, 3, "R10 repeated packet");
    send(K_DATA, 8'd1, 32'd3, 16'd1465, IP_A, 2, "R7 too long");
    send(K_DATA, 8'd1, 32'd358, 16'd8, IP_A, 1, "R7 sequence too high");
    send(K_DATA, 8'd1, 32'd357, 16'd8, IP_A, 1, "R7 highest sequence");
    send(K_DATA, 8'd2, 32'd4, 16'd16, IP_A, 2, "R4 data from wrong host");
    send(K_SIZE, 8'd2, 32'd555, 16'd0, IP_B, 0, "R5 size B");
    send(K_START, 8'd1, 32'd0, 16'd0, IP_A, 0, "R8 start");
    idle(2);
    send(K_SIZE, 8'd2, 32'd9, 16'd0, IP_B, 0, "R8 dropped while waiting");
    idle(3);
    finish_start("R8 start done");
    idle(2);
    send(K_CLOSE, 8'd1, 32'd0, 16'd0, IP_A, 0, "R9 close");
    send(K_DATA, 8'd1, 32'd5, 16'd8, IP_A, 1, "R9 data after close");
    send(K_OPEN, 8'd0, 32'd0, 16'd0, IP_C, 0, "R9 reuse freed number");
    send(K_START, 8'd2, 32'd0, 16'd0, IP_B, 0, "R8 start B");
    idle(4);
    finish_start("R8 start B done");
    idle(4);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule